// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block converts a parallel word into a serial bit stream. It lives in one system-clock domain. It watches four slow external pins: a shift clock, an active-low enable, an active-low load and a serial data input. All four pass through multi-flop synchronizers before any decision is made.

While the load pin is low, the register copies the parallel word on every system clock. While load is high, each rising edge of the effective shift clock moves the word one stage toward the last stage, and a new bit enters at stage 0. The effective shift clock is the OR of the clock pin and the enable pin, so either pin can serve as the clock and the other as the enable.

The last stage drives a true and an inverted serial output. Feeding the true output of one unit into the serial input of the next builds a longer register.

Top module: `piso_gated_shift`

## Requirements
- R1: After reset (rst_ni low) every stage holds 0, so ser_o is 0 and ser_no is 1. The synchronizers reset the clock and enable to high and the load to high, so leaving reset never causes a shift or a load.
- R2: While the synchronized load_ni is low, all stages take par_i on every system clock, so ser_o equals par_i[WIDTH-1]. No clock edge is needed.
- R3: On a shift, stage k takes stage k-1 for k from 1 to WIDTH-1, and stage 0 takes the synchronized ser_i. Stage WIDTH-1 is the last stage.
- R4: The effective shift clock is shclk_i OR shen_ni. A 0-to-1 change of this OR, while the synchronized load_ni is high, makes exactly one shift. Either pin can be toggled as the clock while the other is held low.
- R5: While shen_ni stays high, toggling shclk_i makes no shift.
- R6: A rise of shen_ni while shclk_i is high makes no shift.
- R7: Raising load_ni while shclk_i or shen_ni is high makes no shift.
- R8: A rising effective clock edge while load_ni is low makes no shift. The register keeps following par_i.
- R9: ser_no is always the inverse of ser_o.
- R10: With SYNC_STAGES=2, a pin change driven before clock edge 1 changes the outputs after edge 3 and not before.
- R11: When the ser_o of one unit drives the ser_i of a second unit, and both share the same clock, enable and load pins, the pair acts as one register of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shclk_i | input | 1 | Shift clock pin (asynchronous) |
| shen_ni | input | 1 | Shift enable pin, active low (asynchronous) |
| load_ni | input | 1 | Parallel load, active low, level sensitive (asynchronous) |
| ser_i | input | 1 | Serial data into stage 0 (asynchronous) |
| par_i | input | WIDTH | Parallel data; bit WIDTH-1 goes to the last stage |
| ser_o | output | 1 | Last stage, true |
| ser_no | output | 1 | Last stage, inverted |

## Verification
The assertions check on every cycle that a load copies the parallel word and that a shift moves each stage by exactly one place. They also check that the register is stable when neither a load nor a shift is decoded, that a shift decision lasts only one cycle, and that no shift is decoded while the enable stays high. The bench scenarios cover the behaviour that depends on how the pins move over time: the clock and enable swapping roles, and an enable rise or a load release under a high clock. They also cover the exact three-cycle latency, chaining two units into one long register, and random pin sequences compared against a reference model.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } shift_op_e;
endpackage

// File: rtl/piso_sync_bank.sv
module piso_sync_bank #(
  parameter int unsigned       N       = 4,
  parameter int unsigned       STAGES  = 2,
  parameter logic [N-1:0]      RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/piso_shift_ctrl.sv
module piso_shift_ctrl
  import piso_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clk_s_i,
  input  logic      en_ns_i,
  input  logic      load_ns_i,
  output shift_op_e op_o
);
  logic gate;
  logic gate_q;

  // either pin can gate the other: OR of clock and active-low enable
  assign gate = clk_s_i | en_ns_i;

  // starts high so a pin already high at reset release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b1;
    else         gate_q <= gate;
  end

  always_comb begin
    if (!load_ns_i)            op_o = OP_LOAD;
    else if (gate && !gate_q)  op_o = OP_SHIFT;
    else                       op_o = OP_HOLD;
  end

  // R4
  shift_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_o == OP_SHIFT) |=> (op_o != OP_SHIFT));

  // R5
  no_shift_while_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_ns_i && $past(en_ns_i)) |-> (op_o != OP_SHIFT));
endmodule

// File: rtl/piso_shift_chain.sv
module piso_shift_chain
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  shift_op_e        op_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD:  q_q <= par_i;
        OP_SHIFT: q_q <= {q_q[WIDTH-2:0], ser_i};
        default:  q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;

  // R2
  load_copies_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_LOAD) |=> (q_q == $past(par_i)));

  // R3
  shift_one_place_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_SHIFT) |=> (q_q == {$past(q_q[WIDTH-2:0]), $past(ser_i)}));

  // R5
  hold_keeps_stages_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD) |=> $stable(q_q));
endmodule

// File: rtl/piso_gated_shift.sv
module piso_gated_shift
  import piso_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shclk_i,
  input  logic             shen_ni,
  input  logic             load_ni,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o,
  output logic             ser_no
);
  localparam int unsigned NPINS = 4;
  // bit order: {ser, load_n, en_n, clk}; reset leaves the pins idle
  localparam logic [NPINS-1:0] PIN_RST = 4'b0111;

  logic [NPINS-1:0] pins_s;
  logic [WIDTH-1:0] stages;
  shift_op_e        op;

  piso_sync_bank #(
    .N       (NPINS),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_RST)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ser_i, load_ni, shen_ni, shclk_i}),
    .q_o    (pins_s)
  );

  piso_shift_ctrl u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_s_i   (pins_s[0]),
    .en_ns_i   (pins_s[1]),
    .load_ns_i (pins_s[2]),
    .op_o      (op)
  );

  piso_shift_chain #(
    .WIDTH (WIDTH)
  ) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (op),
    .ser_i  (pins_s[3]),
    .par_i  (par_i),
    .q_o    (stages)
  );

  assign ser_o  = stages[WIDTH-1];
  assign ser_no = ~stages[WIDTH-1];

  // R8
  load_overrides_clock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pins_s[2]) |=> (ser_o == $past(par_i[WIDTH-1])));
endmodule

// File: tb/piso_gated_shift_tb.sv
`timescale 1ns/1ps
module piso_gated_shift_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cp = 1'b0, ce = 1'b0, pl = 1'b1, ds = 1'b0;
  logic [7:0] pa = '0, pb = '0;
  logic       so, sno, sa, sna, sb, snb;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  logic [7:0]  m_a;
  logic [15:0] m_c;
  logic        m_eff;

  always #10 clk = ~clk;

  piso_gated_shift dut_i (.clk_i(clk), .rst_ni(rst_n), .shclk_i(cp), .shen_ni(ce),
    .load_ni(pl), .ser_i(ds), .par_i(pa), .ser_o(so), .ser_no(sno));

  piso_gated_shift chain_a (.clk_i(clk), .rst_ni(rst_n), .shclk_i(cp), .shen_ni(ce),
    .load_ni(pl), .ser_i(ds), .par_i(pa), .ser_o(sa), .ser_no(sna));

  piso_gated_shift chain_b (.clk_i(clk), .rst_ni(rst_n), .shclk_i(cp), .shen_ni(ce),
    .load_ni(pl), .ser_i(sa), .par_i(pb), .ser_o(sb), .ser_no(snb));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, so, m_a[7]);
    chk("R9", sno, ~m_a[7]);
    chk("R11", sb, m_c[15]);
    chk("R9", snb, ~m_c[15]);
  endtask

  task automatic model_apply(input logic c, input logic e, input logic l, input logic d);
    logic eff;
    eff = c | e;
    if (!l) begin
      m_a = pa;
      m_c = {pb, pa};
    end else if (eff && !m_eff) begin
      m_a = {m_a[6:0], d};
      m_c = {m_c[14:0], d};
    end
    m_eff = eff;
  endtask

  // par words change only on steps with load low, so a late load still sees them
  task automatic step(input logic c, input logic e, input logic l, input logic d,
                      input logic [7:0] wa, input logic [7:0] wb, input string tag);
    @(negedge clk);
    cp = c; ce = e; pl = l; ds = d;
    if (!l) begin pa = wa; pb = wb; end
    model_apply(c, e, l, d);
    repeat (4) @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_a = '0; m_c = '0; m_eff = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", so, 1'b0);
    chk("R1", sno, 1'b1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1");

    // R2 level load, no edge
    step(0, 0, 0, 0, 8'hB4, 8'h3C, "R2");
    step(0, 0, 0, 0, 8'h4B, 8'hC3, "R2");
    step(0, 0, 1, 0, 8'h00, 8'h00, "R2");

    // R3/R4 shift with clock pin, enable low
    for (int i = 0; i < 8; i++) begin
      step(1, 0, 1, i[0], 8'h00, 8'h00, "R3");
      step(0, 0, 1, i[0], 8'h00, 8'h00, "R4");
    end
    // R4 enable pin used as clock
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 1, ~i[1], 8'h00, 8'h00, "R4");
      step(0, 0, 1, ~i[1], 8'h00, 8'h00, "R4");
    end

    // R5 enable held high, clock toggles
    step(0, 0, 0, 0, 8'h55, 8'hAA, "R2");
    step(0, 1, 1, 0, 8'h00, 8'h00, "R5");
    for (int i = 0; i < 4; i++) begin
      step(1, 1, 1, 1, 8'h00, 8'h00, "R5");
      step(0, 1, 1, 1, 8'h00, 8'h00, "R5");
    end

    // R6 enable rises under high clock
    step(0, 0, 1, 0, 8'h00, 8'h00, "R6");
    step(1, 0, 1, 0, 8'h00, 8'h00, "R4");
    step(1, 1, 1, 1, 8'h00, 8'h00, "R6");
    step(1, 0, 1, 1, 8'h00, 8'h00, "R6");
    step(1, 1, 1, 1, 8'h00, 8'h00, "R6");

    // R7 load released while clock high
    step(1, 0, 0, 0, 8'hA5, 8'h5A, "R2");
    step(1, 0, 1, 0, 8'h00, 8'h00, "R7");
    step(0, 1, 0, 0, 8'h69, 8'h96, "R2");
    step(0, 1, 1, 1, 8'h00, 8'h00, "R7");

    // R8 clock edge during load
    step(0, 0, 0, 0, 8'hF0, 8'h0F, "R2");
    step(1, 0, 0, 1, 8'hF0, 8'h0F, "R8");
    step(0, 0, 0, 1, 8'h70, 8'h8F, "R8");
    step(0, 0, 1, 1, 8'h00, 8'h00, "R8");

    // R10 latency: load 0xAA, then one clock rise
    step(0, 0, 0, 0, 8'hAA, 8'hAA, "R2");
    step(0, 0, 1, 0, 8'h00, 8'h00, "R10");
    @(negedge clk);
    cp = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R10", so, 1'b1);
    @(negedge clk);
    chk("R10", so, 1'b0);
    model_apply(1, 0, 1, 0);
    repeat (2) @(negedge clk);
    check_all("R10");

    // R11 chained pair: 16 shifts out
    step(0, 0, 0, 0, 8'h93, 8'hE1, "R11");
    step(0, 0, 1, 0, 8'h00, 8'h00, "R11");
    for (int i = 0; i < 16; i++) begin
      step(1, 0, 1, i[2], 8'h00, 8'h00, "R11");
      step(0, 0, 1, i[2], 8'h00, 8'h00, "R11");
    end

    // random pin sequences
    for (int i = 0; i < 200; i++) begin
      logic [7:0] ra, rb;
      ra = 8'($urandom);
      rb = 8'($urandom);
      step(1'($urandom), 1'($urandom % 3 == 0), 1'($urandom % 4 != 0), 1'($urandom),
           ra, rb, "R4");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule